// File: doc/BRIEF.md
# Histogram Rank Selector

This block picks the value of a chosen order statistic from a window of up to 75 pixels of 8 bits, taken one colour plane at a time. It does not compare samples with one another. Each arriving pixel adds one to a counter that belongs to its own value, so the samples end up ordered simply by being counted. When the window closes, a pass walks the counters from one end of the value range and keeps a running total. It stops at the first counter where the total reaches the requested rank. The index of that counter is the answer.

The counters live in a memory inside the block. The memory has one write port and a read port with a registered output. Before each window the block zeroes every counter with a sweep. The rank can be taken from the small end or the large end of the value range, so one block covers both the r-th smallest and the r-th largest value. The circuit that feeds the block assembles the window. It streams the samples in, then pulses start with the rank and the direction, and waits for done.

Top module: `hist_rank_top`

## Requirements
- R1: After reset, and again after every result, busy_o stays high for exactly 256 cycles while every counter is set to zero. While busy_o is high, sample_valid_i and start_i have no effect.
- R2: While busy_o is low, each cycle with sample_valid_i high adds one to the counter selected by sample_i. Only the first 75 samples of a window are counted, and any later samples in that window are ignored.
- R3: start_i, when busy_o is low, closes the window. busy_o is high from the next cycle. done_o is then high for one cycle with the answer on result_o, and the clear sweep of R1 begins in the same cycle.
- R4: If dir_i is 0 when start_i is taken, the result is the rank-th smallest counted sample, found by scanning from value 0 upward. If dir_i is 1, the result is the rank-th largest, found by scanning from value 255 downward.
- R5: Samples with equal values in consecutive cycles are all counted, even though a counter update takes two cycles.
- R6: rank_i counts from 1. A rank of 0 gives the same result as a rank of 1.
- R7: If the rank is larger than the number of counted samples, the result is the last value scanned: 255 when dir_i is 0 and 0 when dir_i is 1.
- R8: After reset, result_o and done_o are 0. result_o changes only in a cycle where done_o is high, and holds its value until the next result.
- R9: A window with no samples behaves as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 8 | Pixel value |
| sample_valid_i | input | 1 | sample_i is valid this cycle |
| rank_i | input | 7 | Requested rank, counted from 1; sampled with start_i |
| dir_i | input | 1 | 0: count from the smallest value, 1: count from the largest; sampled with start_i |
| start_i | input | 1 | Close the window and search for the rank |
| busy_o | output | 1 | Block is clearing or searching; inputs are ignored |
| result_o | output | 8 | Selected pixel value |
| done_o | output | 1 | One-cycle pulse; result_o is valid |

## Verification
The case that is hardest to reach is a counter update colliding with another update still in flight to the same counter. It only occurs when equal values arrive in consecutive cycles. The stimulus therefore streams full windows of one repeated value, and windows drawn from a range of three values, with no idle cycles between samples. It also pushes a window past 75 samples and drives samples and start pulses during the search and the clear sweep, to show that the sample limit holds and that the ignored inputs leave no trace in the next result.

// File: rtl/hist_rank_pkg.sv
package hist_rank_pkg;
  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_ACCUM = 2'd1,
    ST_DRAIN = 2'd2,
    ST_SCAN  = 2'd3
  } hist_state_e;
endpackage

// File: rtl/hist_count_mem.sv
module hist_count_mem #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 7,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  // read returns the old word when the same address is written in the same cycle
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/hist_bin_update.sv
module hist_bin_update #(
  parameter int unsigned BIN_W = 8,
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [BIN_W-1:0] in_bin_i,
  input  logic [CNT_W-1:0] rd_cnt_i,
  output logic             wr_en_o,
  output logic [BIN_W-1:0] wr_bin_o,
  output logic [CNT_W-1:0] wr_cnt_o
);
  logic             s1_v_q, s2_v_q;
  logic [BIN_W-1:0] s1_bin_q, s2_bin_q;
  logic [CNT_W-1:0] s2_cnt_q;
  logic [CNT_W-1:0] base_cnt;

  // stage 2 holds the value written last cycle; memory read missed it
  always_comb begin
    base_cnt = (s2_v_q && (s2_bin_q == s1_bin_q)) ? s2_cnt_q : rd_cnt_i;
    wr_cnt_o = base_cnt + 1'b1;
    wr_en_o  = s1_v_q;
    wr_bin_o = s1_bin_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_q   <= 1'b0;
      s1_bin_q <= '0;
      s2_v_q   <= 1'b0;
      s2_bin_q <= '0;
      s2_cnt_q <= '0;
    end else begin
      s1_v_q   <= in_valid_i;
      s1_bin_q <= in_bin_i;
      s2_v_q   <= s1_v_q;
      s2_bin_q <= s1_bin_q;
      s2_cnt_q <= wr_cnt_o;
    end
  end
endmodule

// File: rtl/hist_bin_scan.sv
module hist_bin_scan #(
  parameter int unsigned BIN_W = 8,
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             dir_i,
  input  logic [CNT_W-1:0] rank_i,
  input  logic [CNT_W-1:0] rd_cnt_i,
  output logic [BIN_W-1:0] rd_addr_o,
  output logic             hit_o,
  output logic [BIN_W-1:0] hit_bin_o
);
  localparam logic [BIN_W-1:0] TOP_BIN = '1;

  logic [BIN_W-1:0] ptr_q, rbin_q, end_bin;
  logic             issue_q, rv_q, dir_q;
  logic [CNT_W:0]   sum_q, acc;

  always_comb begin
    end_bin   = dir_q ? '0 : TOP_BIN;
    acc       = sum_q + {1'b0, rd_cnt_i};
    hit_o     = rv_q && ((acc >= {1'b0, rank_i}) || (rbin_q == end_bin));
    hit_bin_o = rbin_q;
    rd_addr_o = ptr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      rbin_q  <= '0;
      issue_q <= 1'b0;
      rv_q    <= 1'b0;
      dir_q   <= 1'b0;
      sum_q   <= '0;
    end else if (go_i) begin
      dir_q   <= dir_i;
      ptr_q   <= dir_i ? TOP_BIN : '0;
      issue_q <= 1'b1;
      rv_q    <= 1'b0;
      sum_q   <= '0;
    end else begin
      rv_q <= issue_q;
      if (issue_q) begin
        rbin_q <= ptr_q;
        ptr_q  <= dir_q ? ptr_q - 1'b1 : ptr_q + 1'b1;
        if (ptr_q == end_bin) issue_q <= 1'b0;
      end
      if (rv_q) sum_q <= acc;
      if (hit_o) begin
        issue_q <= 1'b0;
        rv_q    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hist_rank_top.sv
module hist_rank_top
  import hist_rank_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WIN    = 75,
  localparam int unsigned CNT_W = $clog2(WIN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              sample_valid_i,
  input  logic [CNT_W-1:0]  rank_i,
  input  logic              dir_i,
  input  logic              start_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o
);
  localparam logic [DATA_W-1:0] LAST_BIN = '1;
  localparam logic [CNT_W-1:0]  WIN_CNT  = CNT_W'(WIN);

  hist_state_e       state_q;
  logic [DATA_W-1:0] clr_q;
  logic [CNT_W-1:0]  taken_q, rank_q;
  logic              dir_q;
  logic [DATA_W-1:0] result_q;
  logic              done_q;

  logic              accept, clearing, scan_go;
  logic              mem_we;
  logic [DATA_W-1:0] mem_waddr, mem_raddr;
  logic [CNT_W-1:0]  mem_wdata, mem_rdata;
  logic              upd_we;
  logic [DATA_W-1:0] upd_bin, scan_addr, hit_bin;
  logic [CNT_W-1:0]  upd_cnt;
  logic              hit;

  always_comb begin
    clearing = (state_q == ST_CLEAR);
    scan_go  = (state_q == ST_DRAIN);
    accept   = (state_q == ST_ACCUM) && sample_valid_i && (taken_q < WIN_CNT);
    if (clearing) begin
      mem_we    = 1'b1;
      mem_waddr = clr_q;
      mem_wdata = '0;
    end else begin
      mem_we    = upd_we;
      mem_waddr = upd_bin;
      mem_wdata = upd_cnt;
    end
    mem_raddr = (state_q == ST_SCAN) ? scan_addr : sample_i;
  end

  hist_count_mem #(.ADDR_W(DATA_W), .DATA_W(CNT_W)) u_mem (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .waddr_i(mem_waddr),
    .wdata_i(mem_wdata),
    .raddr_i(mem_raddr),
    .rdata_o(mem_rdata)
  );

  hist_bin_update #(.BIN_W(DATA_W), .CNT_W(CNT_W)) u_upd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_valid_i(accept),
    .in_bin_i  (sample_i),
    .rd_cnt_i  (mem_rdata),
    .wr_en_o   (upd_we),
    .wr_bin_o  (upd_bin),
    .wr_cnt_o  (upd_cnt)
  );

  hist_bin_scan #(.BIN_W(DATA_W), .CNT_W(CNT_W)) u_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (scan_go),
    .dir_i    (dir_q),
    .rank_i   (rank_q),
    .rd_cnt_i (mem_rdata),
    .rd_addr_o(scan_addr),
    .hit_o    (hit),
    .hit_bin_o(hit_bin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_CLEAR;
      clr_q    <= '0;
      taken_q  <= '0;
      rank_q   <= CNT_W'(1);
      dir_q    <= 1'b0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_CLEAR: begin
          clr_q <= clr_q + 1'b1;
          if (clr_q == LAST_BIN) begin
            state_q <= ST_ACCUM;
            taken_q <= '0;
          end
        end
        ST_ACCUM: begin
          if (accept) taken_q <= taken_q + 1'b1;
          if (start_i) begin
            rank_q  <= (rank_i == '0) ? CNT_W'(1) : rank_i;
            dir_q   <= dir_i;
            state_q <= ST_DRAIN;
          end
        end
        // lets the last in-flight increment land before the first scan read
        ST_DRAIN: state_q <= ST_SCAN;
        ST_SCAN: begin
          if (hit) begin
            result_q <= hit_bin;
            done_q   <= 1'b1;
            clr_q    <= '0;
            state_q  <= ST_CLEAR;
          end
        end
        default: state_q <= ST_CLEAR;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_ACCUM);
  assign result_o = result_q;
  assign done_o   = done_q;
endmodule

// File: rtl/hist_rank_chk.sv
module hist_rank_chk #(
  parameter int unsigned BIN_W = 8,
  parameter int unsigned CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             done_o,
  input logic [BIN_W-1:0] result_o,
  input logic             mem_we,
  input logic             clearing,
  input logic [BIN_W-1:0] mem_waddr,
  input logic [CNT_W-1:0] mem_wdata
);
  p_done_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  p_clear_after_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> clearing);

  p_result_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o);

  p_fwd_incr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we && !clearing && $past(mem_we) && !$past(clearing)
      && (mem_waddr == $past(mem_waddr)))
    |-> (mem_wdata == CNT_W'($past(mem_wdata) + 1'b1)));
endmodule

bind hist_rank_top hist_rank_chk #(.BIN_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o),
  .mem_we   (mem_we),
  .clearing (clearing),
  .mem_waddr(mem_waddr),
  .mem_wdata(mem_wdata)
);

// File: tb/sim_hist_rank_top.sv
module sim_hist_rank_top;
  typedef struct {
    int    val;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sample = '0;
  logic       sample_valid = 1'b0;
  logic [6:0] rank = '0;
  logic       dir = 1'b0;
  logic       start = 1'b0;
  logic       busy, done;
  logic [7:0] result;

  int   n_vec = 0;
  int   n_bad = 0;
  int   cyc = 0;
  exp_t exp_q[$];
  int   win[$];

  always #4 clk = ~clk;

  hist_rank_top u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .sample_i      (sample),
    .sample_valid_i(sample_valid),
    .rank_i        (rank),
    .dir_i         (dir),
    .start_i       (start),
    .busy_o        (busy),
    .result_o      (result),
    .done_o        (done)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check("R1 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, int'(result), e.val);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected 0 cycles left", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  function automatic int model(input int r, input bit d);
    int s[$];
    int n;
    int rr;
    n = (win.size() > 75) ? 75 : win.size();
    for (int i = 0; i < n; i++) s.push_back(win[i]);
    s.sort();
    rr = (r == 0) ? 1 : r;
    if (rr > n) return d ? 0 : 255;
    return d ? s[n-rr] : s[rr-1];
  endfunction

  // gap: idle cycles after each sample; junk: drive traffic while busy
  task automatic run_window(input int r, input bit d, input int gap,
                            input bit junk, input string tag);
    exp_t e;
    e.val = model(r, d);
    e.tag = tag;
    exp_q.push_back(e);
    foreach (win[i]) begin
      sample = 8'(win[i]);
      sample_valid = 1'b1;
      @(negedge clk);
      sample_valid = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
    rank = 7'(r);
    dir = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      if (!busy) begin
        sample_valid = 1'b0;
        start = 1'b0;
        break;
      end
      if (junk) begin
        sample = 8'd250;
        sample_valid = 1'b1;
        start = ~start;
        dir = 1'b1;
        rank = 7'd1;
      end
      @(negedge clk);
    end
    check({tag, " result count"}, exp_q.size(), 0);
  endtask

  initial begin
    int busy_cnt;
    repeat (3) @(negedge clk);
    check("R8 reset done", int'(done), 0);
    check("R8 reset result", int'(result), 0);
    rst_n = 1'b1;
    busy_cnt = 0;
    while (busy) begin
      busy_cnt++;
      @(negedge clk);
    end
    check("R1 clear length", busy_cnt, 256);

    win.delete();
    for (int i = 0; i < 75; i++) win.push_back(int'($urandom_range(0, 255)));
    run_window(10, 1'b0, 0, 1'b0, "R4 smallest rank 10");
    run_window(1, 1'b1, 1, 1'b0, "R4 largest rank 1");
    run_window(40, 1'b1, 2, 1'b0, "R4 largest rank 40");

    win.delete();
    for (int i = 0; i < 75; i++) win.push_back(77);
    run_window(75, 1'b0, 0, 1'b0, "R5 same value rank 75");
    run_window(75, 1'b1, 0, 1'b0, "R5 same value largest rank 75");

    win.delete();
    for (int i = 0; i < 75; i++) win.push_back(int'($urandom_range(40, 42)));
    run_window(30, 1'b1, 0, 1'b0, "R5 narrow range largest 30");
    run_window(50, 1'b0, 0, 1'b0, "R5 narrow range smallest 50");

    win.delete();
    for (int i = 0; i < 5; i++) win.push_back(100 + i);
    run_window(20, 1'b0, 0, 1'b0, "R7 rank over count smallest");
    run_window(20, 1'b1, 0, 1'b0, "R7 rank over count largest");
    run_window(5, 1'b1, 0, 1'b0, "R4 largest rank equal count");

    win.delete();
    run_window(1, 1'b0, 0, 1'b0, "R9 empty smallest");
    run_window(3, 1'b1, 0, 1'b0, "R9 empty largest");

    win.delete();
    for (int i = 0; i < 20; i++) win.push_back(int'($urandom_range(3, 200)));
    run_window(0, 1'b0, 0, 1'b0, "R6 rank zero smallest");
    run_window(0, 1'b1, 1, 1'b0, "R6 rank zero largest");

    win.delete();
    for (int i = 0; i < 75; i++) win.push_back(10);
    for (int i = 0; i < 5; i++) win.push_back(200);
    run_window(1, 1'b1, 0, 1'b0, "R2 samples past 75 ignored");

    win.delete();
    for (int i = 0; i < 3; i++) win.push_back(5);
    run_window(1, 1'b0, 0, 1'b1, "R1 window before busy traffic");
    run_window(1, 1'b1, 0, 1'b0, "R1 busy traffic ignored");

    repeat (20) @(negedge clk);
    check("R3 pending results", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule